// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block is a register front-end that serves a small fixed set of firmware configuration items to boot software. Software writes a 16-bit key into a selector register, then reads the data register repeatedly. Each read returns the next bytes of the chosen item and moves a running byte cursor forward. Bytes past the end of an item, and all bytes of keys that name no item, read as zero. One key bit chooses between a common bank and an architecture-local bank of items.

A companion DMA engine shares the same cursor through a side port. It sees the current key, the cursor offset, the item length and the byte under the cursor. It can move the cursor forward by any count, or load a new key. One item is a feature word whose bit 1 shows whether that engine is present, so software can probe for it.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the current key is 0x0000 and the cursor offset is 0.
- R2: A write at bus address 8 with access size 2 loads the key from `bus_wdata[15:0]` and sets the offset to 0. A selector write of any other size, and any write at address 0, leaves key and offset unchanged.
- R3: Key 0x0000 is a 4-byte item holding 0x51, 0x45, 0x4D, 0x55. Key 0x0001 is a 4-byte little-endian feature word whose byte 0 is 0x03 when `DMA_EN` is 1 (0x01 otherwise) and whose other bytes are 0.
- R4: A read at address 0 with size 1 to 8 returns the item bytes at offsets off..off+size-1, with the lowest offset in `bus_rdata[7:0]`, and advances the offset by the size. Size 0, or a size above 8, is no access.
- R5: Bytes at or past the item length read as zero, and the offset still advances. A key with bit 15 set, or with `key[13:0] >= NUM_ITEMS`, is invalid: its length is 0 and all its bytes read as zero.
- R6: Byte lanes at and above the access size read zero. A read at any address other than 0 returns zero and does not move the cursor.
- R7: Key bit 14 selects the bank. Key 0x4000 holds the 2 bytes 0x5A, 0xC3. Key 0x0002 holds 8 bytes, byte n = 0xA0+n. Key 0x0003 and key 0x4001 are empty.
- R8: `dma_key`, `dma_off`, `dma_len` and `dma_byte` show the current key, the offset, the item length (0 if invalid) and the byte at the offset.
- R9: `dma_adv` advances the offset by `dma_adv_n`. This adds to a bus data read in the same cycle.
- R10: `dma_sel` loads `dma_sel_key` and sets the offset to 0. A bus selector write in the same cycle wins over it. An advance requested in a cycle that has any select is dropped.
- R11: The offset saturates at all ones and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_size | input | clog2(DATA_BYTES)+1 | Access size in bytes |
| bus_wdata | input | 16 | Write data (selector key) |
| bus_rdata | output | 8*DATA_BYTES | Read data, valid in the access cycle |
| dma_key | output | 16 | Current key |
| dma_off | output | OFF_W | Current byte offset |
| dma_len | output | OFF_W | Length of current item |
| dma_byte | output | 8 | Item byte at current offset |
| dma_adv | input | 1 | Advance request |
| dma_adv_n | input | OFF_W | Advance count |
| dma_sel | input | 1 | Reselect request |
| dma_sel_key | input | 16 | Key for reselect |

## Verification
The bench goes after reads that cross an item end. A design that clipped the wrong lane would leak item bytes or drop valid ones in the upper lanes. Keys with bit 15 set or with an index past the table are also exercised: a decoder that ignored bit 15 would alias them onto real items. The bench also covers a selector write and a DMA select in the same cycle, and a bus read combined with a DMA advance. A wrong priority would load the wrong key, and a lost sum would leave the cursor short. Finally, a cursor driven to its maximum shows whether the offset wraps back onto item data.

// File: rtl/cfg_item_pkg.sv
// Shared key layout and item table contents for the configuration item port.
// Assumes keys are 16 bits: bit 15 marks invalid, bit 14 picks the bank.
package cfg_item_pkg;
    localparam int KEY_W       = 16;
    localparam int IDX_W       = 14;
    localparam int BANK_BIT    = 14;
    localparam int INVALID_BIT = 15;

    typedef logic [KEY_W-1:0] cfg_key_t;

    typedef struct packed {
        logic             valid;
        logic             bank;
        logic [IDX_W-1:0] idx;
    } item_ref_t;

    // Split a key into bank and index and decide whether it names an item.
    function automatic item_ref_t decode_key(cfg_key_t key, logic [IDX_W:0] n_items);
        item_ref_t r;
        r.bank  = key[BANK_BIT];
        r.idx   = key[IDX_W-1:0];
        r.valid = !key[INVALID_BIT] && ({1'b0, r.idx} < n_items);
        return r;
    endfunction

    // Length in bytes of an item; zero for invalid or empty items.
    function automatic logic [7:0] item_len(item_ref_t it);
        logic [7:0] n;
        n = 8'd0;
        if (it.valid) begin
            if (!it.bank) begin
                case (it.idx)
                    14'd0:   n = 8'd4;
                    14'd1:   n = 8'd4;
                    14'd2:   n = 8'd8;
                    default: n = 8'd0;
                endcase
            end else begin
                n = (it.idx == 14'd0) ? 8'd2 : 8'd0;
            end
        end
        return n;
    endfunction

    // Raw item byte before end-of-item clipping.
    function automatic logic [7:0] item_raw(item_ref_t it, logic [7:0] off8, logic dma_en);
        logic [7:0] b;
        b = 8'h00;
        if (!it.bank) begin
            case (it.idx)
                14'd0: begin
                    case (off8[1:0])
                        2'd0:    b = 8'h51;
                        2'd1:    b = 8'h45;
                        2'd2:    b = 8'h4D;
                        default: b = 8'h55;
                    endcase
                end
                14'd1:   b = (off8 == 8'd0) ? {6'b0, dma_en, 1'b1} : 8'h00;
                14'd2:   b = 8'hA0 + off8;
                default: b = 8'h00;
            endcase
        end else if (it.idx == 14'd0) begin
            b = (off8 == 8'd0) ? 8'h5A : 8'hC3;
        end
        return b;
    endfunction
endpackage

// File: rtl/cfg_lane_rom.sv
// One byte lane of item lookup: returns the item byte at a given offset,
// or zero when the item is invalid or the offset is at or past its end.
// Assumes the offset carries one spare bit so lane offsets never wrap.
module cfg_lane_rom
    import cfg_item_pkg::*;
#(
    parameter int OFF_W  = 16,
    parameter bit DMA_EN = 1'b1
) (
    input  item_ref_t        item_i,
    input  logic [OFF_W:0]   off_i,
    output logic [7:0]       byte_o
);
    logic [7:0] len8;

    // Clip the table byte against the item length.
    always_comb begin
        len8 = item_len(item_i);
        if (item_i.valid && (off_i < {{(OFF_W+1-8){1'b0}}, len8}))
            byte_o = item_raw(item_i, off_i[7:0], DMA_EN);
        else
            byte_o = 8'h00;
    end
endmodule

// File: rtl/cfg_cursor.sv
// Holds the current key and the byte offset within the selected item.
// A load sets a new key and clears the offset; otherwise the offset grows
// by the step and saturates at its maximum value.
module cfg_cursor
    import cfg_item_pkg::*;
#(
    parameter int OFF_W  = 16,
    parameter int STEP_W = OFF_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  cfg_key_t         load_key_i,
    input  logic [STEP_W-1:0] step_i,
    output cfg_key_t         key_o,
    output logic [OFF_W-1:0] off_o
);
    localparam int SUM_W = (STEP_W > OFF_W ? STEP_W : OFF_W) + 1;
    localparam logic [SUM_W-1:0] OFF_MAX = {{(SUM_W-OFF_W){1'b0}}, {OFF_W{1'b1}}};

    logic [SUM_W-1:0] sum;

    // Next offset with saturation.
    always_comb begin
        sum = {{(SUM_W-OFF_W){1'b0}}, off_o} + {{(SUM_W-STEP_W){1'b0}}, step_i};
    end

    // Key and offset registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_o <= '0;
            off_o <= '0;
        end else if (load_i) begin
            key_o <= load_key_i;
            off_o <= '0;
        end else if (sum > OFF_MAX) begin
            off_o <= {OFF_W{1'b1}};
        end else begin
            off_o <= sum[OFF_W-1:0];
        end
    end
endmodule

// File: rtl/cfg_item_port.sv
// Register front-end for keyed configuration items. Selector at address 8
// (16-bit writes), data at address 0 (reads of 1..DATA_BYTES bytes). A side
// port shares the cursor with a DMA engine. Assumes OFF_W >= 8.
module cfg_item_port
    import cfg_item_pkg::*;
#(
    parameter int NUM_ITEMS  = 4,
    parameter int OFF_W      = 16,
    parameter int DATA_BYTES = 8,
    parameter int ADDR_W     = 5,
    parameter bit DMA_EN     = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_en,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [$clog2(DATA_BYTES):0]   bus_size,
    input  logic [15:0]                   bus_wdata,
    output logic [8*DATA_BYTES-1:0]       bus_rdata,
    output logic [15:0]                   dma_key,
    output logic [OFF_W-1:0]              dma_off,
    output logic [OFF_W-1:0]              dma_len,
    output logic [7:0]                    dma_byte,
    input  logic                          dma_adv,
    input  logic [OFF_W-1:0]              dma_adv_n,
    input  logic                          dma_sel,
    input  logic [15:0]                   dma_sel_key
);
    localparam int SZ_W   = $clog2(DATA_BYTES) + 1;
    localparam int STEP_W = OFF_W + 1;
    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] SEL_ADDR  = ADDR_W'(8);
    localparam logic [IDX_W:0]    N_ITEMS_V = (IDX_W+1)'(NUM_ITEMS);

    logic              rd_go, sel_go, load;
    cfg_key_t          load_key;
    logic [STEP_W-1:0] step;
    item_ref_t         item;
    logic [7:0]        lane_byte [DATA_BYTES];

    // Decode the bus access and merge it with DMA requests.
    always_comb begin
        rd_go    = bus_en && !bus_we && (bus_addr == DATA_ADDR) &&
                   (bus_size != '0) && (bus_size <= SZ_W'(DATA_BYTES));
        sel_go   = bus_en && bus_we && (bus_addr == SEL_ADDR) && (bus_size == SZ_W'(2));
        load     = sel_go || dma_sel;
        load_key = sel_go ? bus_wdata : dma_sel_key;
        step     = (rd_go ? {{(STEP_W-SZ_W){1'b0}}, bus_size} : '0) +
                   ((dma_adv && !load) ? {1'b0, dma_adv_n} : '0);
    end

    cfg_cursor #(.OFF_W(OFF_W), .STEP_W(STEP_W)) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_key_i (load_key),
        .step_i     (step),
        .key_o      (dma_key),
        .off_o      (dma_off)
    );

    // Key decode and item length for the side port.
    always_comb begin
        item    = decode_key(dma_key, N_ITEMS_V);
        dma_len = {{(OFF_W-8){1'b0}}, item_len(item)};
    end

    generate
        for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
            logic [OFF_W:0] lane_off;
            assign lane_off = {1'b0, dma_off} + (OFF_W+1)'(g);
            cfg_lane_rom #(.OFF_W(OFF_W), .DMA_EN(DMA_EN)) u_rom (
                .item_i (item),
                .off_i  (lane_off),
                .byte_o (lane_byte[g])
            );
            assign bus_rdata[8*g +: 8] =
                (rd_go && (SZ_W'(g) < bus_size)) ? lane_byte[g] : 8'h00;
        end
    endgenerate

    assign dma_byte = lane_byte[0];
endmodule

// File: rtl/cfg_item_port_chk.sv
// Assertion checker for cfg_item_port, attached by bind below.
module cfg_item_port_chk #(
    parameter int OFF_W      = 16,
    parameter int DATA_BYTES = 8,
    parameter int ADDR_W     = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_en,
    input logic                        bus_we,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [$clog2(DATA_BYTES):0] bus_size,
    input logic [15:0]                 bus_wdata,
    input logic [8*DATA_BYTES-1:0]     bus_rdata,
    input logic [15:0]                 dma_key,
    input logic [OFF_W-1:0]            dma_off,
    input logic [OFF_W-1:0]            dma_len,
    input logic [7:0]                  dma_byte,
    input logic                        dma_adv,
    input logic [OFF_W-1:0]            dma_adv_n,
    input logic                        dma_sel,
    input logic [15:0]                 dma_sel_key
);
    localparam int SZ_W = $clog2(DATA_BYTES) + 1;
    logic selw, rdw;
    assign selw = bus_en && bus_we && (bus_addr == ADDR_W'(8)) && (bus_size == SZ_W'(2));
    assign rdw  = bus_en && !bus_we && (bus_addr == '0) && (bus_size != '0) &&
                  (bus_size <= SZ_W'(DATA_BYTES));

    AST_SEL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        selw |=> (dma_key == $past(bus_wdata)) && (dma_off == '0)); // R2
    AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (rdw && !selw && !dma_sel && !dma_adv && (dma_off < {1'b0, {(OFF_W-1){1'b1}}}))
        |=> dma_off == $past(dma_off) + OFF_W'($past(bus_size))); // R4
    AST_PAST_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_off >= dma_len) |-> (dma_byte == 8'h00)); // R5
    AST_UPPER_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdw && (bus_size < SZ_W'(DATA_BYTES))) |-> ((bus_rdata >> (8*bus_size)) == '0)); // R6
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_en && !dma_sel && !dma_adv) |=> $stable(dma_key) && $stable(dma_off)); // R8
    AST_DMA_SEL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_sel && !selw) |=> (dma_key == $past(dma_sel_key)) && (dma_off == '0)); // R10
    AST_OFF_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        ((dma_off == {OFF_W{1'b1}}) && !selw && !dma_sel) |=> (dma_off == {OFF_W{1'b1}})); // R11
endmodule

bind cfg_item_port cfg_item_port_chk #(
    .OFF_W(OFF_W), .DATA_BYTES(DATA_BYTES), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dma_key(dma_key), .dma_off(dma_off),
    .dma_len(dma_len), .dma_byte(dma_byte), .dma_adv(dma_adv),
    .dma_adv_n(dma_adv_n), .dma_sel(dma_sel), .dma_sel_key(dma_sel_key)
);

// File: tb/cfg_item_port_bench.sv
// Bench: behavioural reference model of key, offset and item contents,
// compared against every output on every stimulus cycle.
module cfg_item_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_size = '0;
    logic [15:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [15:0] dma_key;
    logic [15:0] dma_off, dma_len;
    logic [7:0]  dma_byte;
    logic        dma_adv = 1'b0, dma_sel = 1'b0;
    logic [15:0] dma_adv_n = '0, dma_sel_key = '0;

    int checks = 0;
    int errors = 0;
    int m_key = 0;
    longint m_off = 0;

    always #5 clk = ~clk;

    cfg_item_port u_cfg_item_port (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .dma_key(dma_key), .dma_off(dma_off),
        .dma_len(dma_len), .dma_byte(dma_byte), .dma_adv(dma_adv),
        .dma_adv_n(dma_adv_n), .dma_sel(dma_sel), .dma_sel_key(dma_sel_key)
    );

    function automatic longint ref_len(int key);
        int idx;
        idx = key & 'h3FFF;
        if ((key & 'h8000) != 0 || idx >= 4) return 0;
        if ((key & 'h4000) == 0) begin
            if (idx == 0 || idx == 1) return 4;
            if (idx == 2) return 8;
            return 0;
        end
        return (idx == 0) ? 2 : 0;
    endfunction

    function automatic longint ref_byte(int key, longint off);
        int idx;
        idx = key & 'h3FFF;
        if (off >= ref_len(key)) return 0;
        if ((key & 'h4000) != 0) return (off == 0) ? 'h5A : 'hC3;
        if (idx == 0) begin
            case (off)
                0: return 'h51;
                1: return 'h45;
                2: return 'h4D;
                default: return 'h55;
            endcase
        end
        if (idx == 1) return (off == 0) ? 3 : 0;
        return 'hA0 + off;
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One stimulus cycle: drive, compare at the falling edge, update the model.
    task automatic step(string tag, bit en, bit we, bit [4:0] addr, bit [3:0] size,
                        bit [15:0] wd, bit dsel, bit [15:0] dkey, bit dadv, bit [15:0] dn);
        bit rd, selw;
        longint exp_rd;
        bus_en = en; bus_we = we; bus_addr = addr; bus_size = size; bus_wdata = wd;
        dma_sel = dsel; dma_sel_key = dkey; dma_adv = dadv; dma_adv_n = dn;
        rd   = en && !we && addr == 0 && size >= 1 && size <= 8;
        selw = en && we && addr == 8 && size == 2;
        exp_rd = 0;
        if (rd)
            for (int i = 0; i < size; i++)
                exp_rd = exp_rd | (ref_byte(m_key, m_off + i) << (8*i));
        @(negedge clk);
        chk(tag, "key",   dma_key,   m_key);
        chk(tag, "off",   dma_off,   m_off);
        chk(tag, "len",   dma_len,   ref_len(m_key));
        chk(tag, "byte",  dma_byte,  ref_byte(m_key, m_off));
        chk(tag, "rdata", bus_rdata, exp_rd);
        @(posedge clk);
        if (selw) begin
            m_key = wd; m_off = 0;
        end else if (dsel) begin
            m_key = dkey; m_off = 0;
        end else begin
            m_off = m_off + (rd ? size : 0) + (dadv ? dn : 0);
            if (m_off > 'hFFFF) m_off = 'hFFFF;
        end
        #1;
    endtask

    task automatic rd(string tag, bit [3:0] size);
        step(tag, 1, 0, 5'd0, size, 16'h0, 0, 16'h0, 0, 16'h0);
    endtask

    task automatic sel(string tag, bit [15:0] key);
        step(tag, 1, 1, 5'd8, 4'd2, key, 0, 16'h0, 0, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: state straight after reset; R3 signature
        step("R1", 0, 0, 5'd0, 4'd0, 16'h0, 0, 16'h0, 0, 16'h0);
        rd("R3", 4'd4);
        rd("R5", 4'd1);
        rd("R5", 4'd8);
        sel("R3", 16'h0001);
        rd("R3", 4'd4);
        // R4 ramp item in several sizes, crossing the end
        sel("R7", 16'h0002);
        rd("R4", 4'd8);
        rd("R5", 4'd8);
        sel("R4", 16'h0002);
        rd("R4", 4'd3);
        rd("R4", 4'd2);
        rd("R5", 4'd8);
        // R2 ignored writes
        sel("R2", 16'h0000);
        step("R2", 1, 1, 5'd8, 4'd4, 16'h0002, 0, 16'h0, 0, 16'h0);
        step("R2", 1, 1, 5'd0, 4'd2, 16'h0002, 0, 16'h0, 0, 16'h0);
        step("R2", 1, 1, 5'd8, 4'd1, 16'h0001, 0, 16'h0, 0, 16'h0);
        rd("R2", 4'd2);
        // R6 other address and bad sizes
        step("R6", 1, 0, 5'd8, 4'd2, 16'h0, 0, 16'h0, 0, 16'h0);
        step("R6", 1, 0, 5'd4, 4'd4, 16'h0, 0, 16'h0, 0, 16'h0);
        step("R4", 1, 0, 5'd0, 4'd0, 16'h0, 0, 16'h0, 0, 16'h0);
        step("R4", 1, 0, 5'd0, 4'd9, 16'h0, 0, 16'h0, 0, 16'h0);
        rd("R6", 4'd1);
        // R7 banks and empty items; R5 invalid keys
        sel("R7", 16'h4000);
        rd("R7", 4'd4);
        sel("R7", 16'h4001);
        rd("R7", 4'd2);
        sel("R7", 16'h0003);
        rd("R7", 4'd4);
        sel("R5", 16'h0004);
        rd("R5", 4'd8);
        sel("R5", 16'h8000);
        rd("R5", 4'd4);
        sel("R5", 16'hC002);
        rd("R5", 4'd8);
        // R8 R9 side port
        step("R10", 0, 0, 5'd0, 4'd0, 16'h0, 1, 16'h0002, 0, 16'h0);
        step("R9", 0, 0, 5'd0, 4'd0, 16'h0, 0, 16'h0, 1, 16'd3);
        step("R8", 0, 0, 5'd0, 4'd0, 16'h0, 0, 16'h0, 0, 16'h0);
        step("R9", 1, 0, 5'd0, 4'd2, 16'h0, 0, 16'h0, 1, 16'd1);
        step("R8", 0, 0, 5'd0, 4'd0, 16'h0, 0, 16'h0, 0, 16'h0);
        // R10 priority
        step("R10", 1, 1, 5'd8, 4'd2, 16'h4000, 1, 16'h0001, 0, 16'h0);
        rd("R10", 4'd1);
        step("R10", 0, 0, 5'd0, 4'd0, 16'h0, 1, 16'h0000, 1, 16'd2);
        step("R10", 1, 1, 5'd8, 4'd2, 16'h0002, 0, 16'h0, 1, 16'd5);
        rd("R10", 4'd2);
        // R11 saturation
        step("R11", 0, 0, 5'd0, 4'd0, 16'h0, 0, 16'h0, 1, 16'hFFFF);
        step("R11", 0, 0, 5'd0, 4'd0, 16'h0, 0, 16'h0, 1, 16'hFFFF);
        rd("R11", 4'd8);
        rd("R11", 4'd8);
        sel("R11", 16'h0002);
        rd("R11", 4'd1);
        finish_sim();
    end
endmodule